// File: doc/BRIEF.md
# Polled Floppy Controller Register Front End

This block sits between a host bus and the rest of a polled floppy disk controller. Two state-latch select inputs decide what a host read returns: the incoming data byte, a handshake byte or a status byte. The same two inputs, when both are high, turn a host write strobe into a register write. That write goes to the 5-bit mode register while the drive is off. While the drive is on, it goes to the outgoing data byte. The controller raises no interrupts, so software learns everything by polling these registers.

The block also owns the drive enable. A motor request input turns the drive on. When the request drops, mode bit 2 picks what happens next. If the bit is 0, the enable is held for a fixed number of clock cycles. If the bit is 1, the enable drops at once. The four drive command lines are passed through a register to the drive. The drive's one-bit sense line is returned in the status byte. The data shifter, the serial bit engine and the drive mechanics are outside this block: data-ready and underrun arrive as plain inputs.

Top module: `fdc_reg_front`

## Requirements
- R1: A read with (selA, selB) = (0,0) returns `dataRegIn`. A read with (1,0) returns the status byte. A read with (0,1) returns the handshake byte. A read with (1,1) returns 0x00.
- R2: A clock edge with `wrStrobe`=1, selA=1, selB=1 and the drive off loads `wrData[4:0]` into the mode register. `modeOut` and status bits 4..0 show the new value from the next cycle on. `wrData[7:5]` is discarded.
- R3: The status byte is {senseIn, 0, driveEn, mode[4:0]}, with bit 7 first.
- R4: The handshake byte is {dataReady, not underrun, 000000}, with bit 7 first.
- R5: A write with both selects high while the drive is on leaves the mode register unchanged. In the next cycle it presents `wrData` on `dataRegOut` and pulses `dataWrStb` for one cycle.
- R6: A write strobe with any other select code changes neither the mode register nor `dataWrStb`.
- R7: `driveEn` rises at the first clock edge that samples `motorReq` high while the drive is off.
- R8: With mode bit 2 = 0, `driveEn` falls exactly `DELAY_CYCLES` clock edges after the first edge that samples `motorReq` low.
- R9: With mode bit 2 = 1, `driveEn` falls at the first edge that samples `motorReq` low.
- R10: `motorReq` going high again while a delayed turn-off is counting cancels the turn-off, and the drive stays on.
- R11: An `underrunIn` pulse sets a sticky underrun flag, which shows as handshake bit 6 = 0. A mode write or a drive turn-on clears the flag. If a set and a clear fall on the same edge, the set wins.
- R12: `driveCmdOut` equals `driveCmdIn` as sampled at the previous clock edge.
- R13: After reset, the mode register is 0, `driveEn` is 0, the underrun flag is clear, `driveCmdOut` is 0 and `dataWrStb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| selA | input | 1 | State latch A; high selects status, or write when selB is also high |
| selB | input | 1 | State latch B; high selects handshake, or write when selA is also high |
| wrStrobe | input | 1 | Host write strobe |
| wrData | input | 8 | Host write byte |
| rdData | output | 8 | Host read byte |
| dataRegIn | input | 8 | Byte from the read shifter |
| dataRegOut | output | 8 | Byte to the write shifter |
| dataWrStb | output | 1 | One-cycle pulse: `dataRegOut` holds a new byte |
| dataReady | input | 1 | Controller ready for data |
| underrunIn | input | 1 | Write underrun event pulse |
| motorReq | input | 1 | Motor on request (level) |
| driveEn | output | 1 | Drive enable |
| modeOut | output | 5 | Mode register contents |
| senseIn | input | 1 | Drive sense line |
| driveCmdIn | input | 4 | Drive command lines from host |
| driveCmdOut | output | 4 | Registered drive command lines |

## Verification
A table of mode bytes is written while the drive is off. Each byte is paired with a sense level. The status byte then shows whether the low five bits were stored, whether the reserved bits were dropped, and whether sense reaches bit 7 on its own. Writes that follow a drive turn-on separate the mode path from the data path. Writes with the mixed select codes show that the decode ignores them. The turn-off tests count edges to the exact cycle, using the delayed and immediate settings of mode bit 2 and a re-request during the delay. The underrun tests clear the flag once through each clear path and then set and clear it on the same edge.

// File: rtl/fdc_reg_pkg.sv
package fdc_reg_pkg;
  localparam int DATA_W       = 8;
  localparam int MODE_W       = 5;
  localparam int CMD_W        = 4;
  localparam int NO_DELAY_BIT = 2;

  typedef struct packed {
    logic modeWr;
    logic dataWr;
    logic clrUnderrun;
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    DRV_OFF   = 2'd0,
    DRV_ON    = 2'd1,
    DRV_COAST = 2'd2
  } drvState_e;
endpackage

// File: rtl/fdc_reg_ctrl.sv
module fdc_reg_ctrl
  import fdc_reg_pkg::*;
#(
  parameter int DELAY_CYCLES = 50_000_000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         selA,
  input  logic         selB,
  input  logic         wrStrobe,
  input  logic         motorReq,
  input  logic         modeNoDelay,
  output ctrlStrobes_t strobes,
  output logic         driveEn
);
  localparam int CNT_W = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DELAY_CYCLES - 1);

  drvState_e state, stateNext;
  logic [CNT_W-1:0] coastCnt, coastCntNext;
  logic wrSel;

  assign wrSel   = wrStrobe && selA && selB;
  assign driveEn = (state != DRV_OFF);

  always_comb begin
    strobes.modeWr      = wrSel && !driveEn;
    strobes.dataWr      = wrSel && driveEn;
    strobes.clrUnderrun = strobes.modeWr || (state == DRV_OFF && motorReq);
  end

  always_comb begin
    stateNext    = state;
    coastCntNext = coastCnt;
    unique case (state)
      DRV_OFF:   if (motorReq) stateNext = DRV_ON;
      DRV_ON: begin
        if (!motorReq) begin
          if (modeNoDelay) begin
            stateNext = DRV_OFF;
          end else begin
            stateNext    = DRV_COAST;
            coastCntNext = CNT_LOAD;
          end
        end
      end
      DRV_COAST: begin
        if (motorReq)            stateNext = DRV_ON;
        else if (coastCnt == '0) stateNext = DRV_OFF;
        else                     coastCntNext = coastCnt - 1'b1;
      end
      default:   stateNext = DRV_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= DRV_OFF;
      coastCnt <= '0;
    end else begin
      state    <= stateNext;
      coastCnt <= coastCntNext;
    end
  end

  // R5: one write goes to exactly one destination
  a_r5_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobes.modeWr && strobes.dataWr));

  // R7: the drive turns on after a request while off
  a_r7_turn_on: assert property (@(posedge clk) disable iff (!rst_n)
    (!driveEn && motorReq) |=> driveEn);

  // R9: turn-off is immediate when the no-delay bit is set
  a_r9_immediate_off: assert property (@(posedge clk) disable iff (!rst_n)
    (state == DRV_ON && !motorReq && modeNoDelay) |=> !driveEn);

  // R8: the enable holds while the count runs and drops when it expires
  a_r8_hold_while_counting: assert property (@(posedge clk) disable iff (!rst_n)
    (state == DRV_COAST && !motorReq && coastCnt != '0) |=> driveEn);
  a_r8_drop_at_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (state == DRV_COAST && !motorReq && coastCnt == '0) |=> !driveEn);

  // R10: a request during the delay cancels the turn-off
  a_r10_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (state == DRV_COAST && motorReq) |=> (driveEn && state == DRV_ON));
endmodule

// File: rtl/fdc_reg_dp.sv
module fdc_reg_dp
  import fdc_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strobes,
  input  logic              selA,
  input  logic              selB,
  input  logic              driveEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] dataRegIn,
  input  logic              dataReady,
  input  logic              underrunIn,
  input  logic              senseIn,
  input  logic [CMD_W-1:0]  driveCmdIn,
  output logic [DATA_W-1:0] rdData,
  output logic [MODE_W-1:0] modeOut,
  output logic [DATA_W-1:0] dataRegOut,
  output logic              dataWrStb,
  output logic [CMD_W-1:0]  driveCmdOut
);
  localparam int RSV_W = DATA_W - MODE_W - 2;
  localparam int HS_PAD = DATA_W - 2;

  logic [MODE_W-1:0] modeReg;
  logic              underrunFlag;
  logic [DATA_W-1:0] statusByte, handshakeByte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeReg      <= '0;
      underrunFlag <= 1'b0;
      dataRegOut   <= '0;
      dataWrStb    <= 1'b0;
      driveCmdOut  <= '0;
    end else begin
      if (strobes.modeWr) modeReg <= wrData[MODE_W-1:0];
      if (underrunIn)                underrunFlag <= 1'b1;
      else if (strobes.clrUnderrun)  underrunFlag <= 1'b0;
      dataWrStb <= strobes.dataWr;
      if (strobes.dataWr) dataRegOut <= wrData;
      driveCmdOut <= driveCmdIn;
    end
  end

  assign modeOut       = modeReg;
  assign statusByte    = {senseIn, {RSV_W{1'b0}}, driveEn, modeReg};
  assign handshakeByte = {dataReady, !underrunFlag, {HS_PAD{1'b0}}};

  always_comb begin
    unique case ({selA, selB})
      2'b00:   rdData = dataRegIn;
      2'b01:   rdData = handshakeByte;
      2'b10:   rdData = statusByte;
      default: rdData = '0;
    endcase
  end

  // R11: an underrun event always leaves the flag set
  a_r11_underrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    underrunIn |=> underrunFlag);
  // R11: the flag holds until a clear strobe
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underrunFlag && !strobes.clrUnderrun) |=> underrunFlag);

  // R12: the command lines are delayed by one register
  a_r12_cmd_delay: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (driveCmdOut == $past(driveCmdIn)));
endmodule

// File: rtl/fdc_reg_front.sv
module fdc_reg_front
  import fdc_reg_pkg::*;
#(
  parameter int DELAY_CYCLES = 50_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              selA,
  input  logic              selB,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] dataRegIn,
  output logic [DATA_W-1:0] dataRegOut,
  output logic              dataWrStb,
  input  logic              dataReady,
  input  logic              underrunIn,
  input  logic              motorReq,
  output logic              driveEn,
  output logic [MODE_W-1:0] modeOut,
  input  logic              senseIn,
  input  logic [CMD_W-1:0]  driveCmdIn,
  output logic [CMD_W-1:0]  driveCmdOut
);
  ctrlStrobes_t strobes;

  fdc_reg_ctrl #(.DELAY_CYCLES(DELAY_CYCLES)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .selA        (selA),
    .selB        (selB),
    .wrStrobe    (wrStrobe),
    .motorReq    (motorReq),
    .modeNoDelay (modeOut[NO_DELAY_BIT]),
    .strobes     (strobes),
    .driveEn     (driveEn)
  );

  fdc_reg_dp u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .selA        (selA),
    .selB        (selB),
    .driveEn     (driveEn),
    .wrData      (wrData),
    .dataRegIn   (dataRegIn),
    .dataReady   (dataReady),
    .underrunIn  (underrunIn),
    .senseIn     (senseIn),
    .driveCmdIn  (driveCmdIn),
    .rdData      (rdData),
    .modeOut     (modeOut),
    .dataRegOut  (dataRegOut),
    .dataWrStb   (dataWrStb),
    .driveCmdOut (driveCmdOut)
  );

  // R2: the mode register changes only after a write while the drive is off
  a_r2_mode_write_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(modeOut) |-> $past(wrStrobe && selA && selB && !driveEn));

  // R5: a write while the drive is on feeds the data path, not the mode
  a_r5_data_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wrStrobe && selA && selB && driveEn) |=>
      (dataWrStb && dataRegOut == $past(wrData) && $stable(modeOut)));

  // R6: no data strobe without a full write select
  a_r6_no_stray_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrStrobe && selA && selB) |=> !dataWrStb);
endmodule

// File: tb/fdc_reg_front_bench.sv
module fdc_reg_front_bench;
  localparam int DLY = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic selA = 0, selB = 0, wrStrobe = 0;
  logic [7:0] wrData = 0, dataRegIn = 0;
  logic [7:0] rdData, dataRegOut;
  logic dataWrStb, dataReady = 0, underrunIn = 0, motorReq = 0, driveEn, senseIn = 0;
  logic [4:0] modeOut;
  logic [3:0] driveCmdIn = 0, driveCmdOut;

  int nChecks = 0, nFails = 0;

  // {mode byte written, sense level, expected status byte}
  localparam logic [16:0] VEC [6] = '{
    {8'h1F, 1'b1, 8'h9F},
    {8'hE0, 1'b0, 8'h00},
    {8'h15, 1'b1, 8'h95},
    {8'h0A, 1'b0, 8'h0A},
    {8'hFF, 1'b0, 8'h1F},
    {8'h04, 1'b1, 8'h84}
  };

  fdc_reg_front #(.DELAY_CYCLES(DLY)) u_fdc_reg_front (
    .clk(clk), .rst_n(rst_n), .selA(selA), .selB(selB), .wrStrobe(wrStrobe),
    .wrData(wrData), .rdData(rdData), .dataRegIn(dataRegIn), .dataRegOut(dataRegOut),
    .dataWrStb(dataWrStb), .dataReady(dataReady), .underrunIn(underrunIn),
    .motorReq(motorReq), .driveEn(driveEn), .modeOut(modeOut), .senseIn(senseIn),
    .driveCmdIn(driveCmdIn), .driveCmdOut(driveCmdOut));

  always #10 clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic readReg(logic a, logic b, output logic [7:0] val);
    selA = a; selB = b; #1; val = rdData;
  endtask

  task automatic hostWrite(logic a, logic b, logic [7:0] d);
    @(negedge clk); selA = a; selB = b; wrData = d; wrStrobe = 1;
    @(negedge clk); wrStrobe = 0;
  endtask

  task automatic pulseUnderrun();
    @(negedge clk); underrunIn = 1;
    @(negedge clk); underrunIn = 0;
  endtask

  initial begin
    #(200000 * 20);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R13 reset state
    check("R13 driveEn", {7'd0, driveEn}, 8'h00);
    check("R13 dataWrStb", {7'd0, dataWrStb}, 8'h00);
    check("R13 cmdOut", {4'd0, driveCmdOut}, 8'h00);
    check("R13 mode", {3'd0, modeOut}, 8'h00);
    readReg(1, 0, v); check("R13 status", v, 8'h00);
    readReg(0, 1, v); check("R13 handshake", v, 8'h40);

    // R2 / R3 table walk
    for (int i = 0; i < 6; i++) begin
      hostWrite(1, 1, VEC[i][16:9]);
      senseIn = VEC[i][8];
      readReg(1, 0, v); check("R2/R3 status", v, VEC[i][7:0]);
    end
    senseIn = 0;

    // R1 decode
    dataRegIn = 8'h5A;
    readReg(0, 0, v); check("R1 data read", v, 8'h5A);
    readReg(1, 1, v); check("R1 write code read", v, 8'h00);

    // R4 handshake ready
    dataReady = 1;
    readReg(0, 1, v); check("R4 ready", v, 8'hC0);

    // R6 ignored writes (mode is 04)
    hostWrite(1, 0, 8'h1F);
    check("R6 dataWrStb", {7'd0, dataWrStb}, 8'h00);
    hostWrite(0, 1, 8'h1B);
    check("R6 mode kept", {3'd0, modeOut}, 8'h04);
    check("R6 dataWrStb b", {7'd0, dataWrStb}, 8'h00);

    // R11 sticky, clear by mode write, set wins
    pulseUnderrun();
    readReg(0, 1, v); check("R11 set", v, 8'h80);
    repeat (3) @(negedge clk);
    readReg(0, 1, v); check("R11 sticky", v, 8'h80);
    hostWrite(1, 1, 8'h00);
    readReg(0, 1, v); check("R11 cleared by mode write", v, 8'hC0);
    @(negedge clk); selA = 1; selB = 1; wrData = 8'h00; wrStrobe = 1; underrunIn = 1;
    @(negedge clk); wrStrobe = 0; underrunIn = 0;
    readReg(0, 1, v); check("R11 set wins", v, 8'h80);

    // R7 turn-on, also clears underrun
    motorReq = 1;
    @(negedge clk);
    check("R7 driveEn", {7'd0, driveEn}, 8'h01);
    readReg(0, 1, v); check("R11 cleared by turn-on", v, 8'hC0);
    readReg(1, 0, v); check("R3 drive bit", v, 8'h20);

    // R5 write while on
    hostWrite(1, 1, 8'h3C);
    check("R5 strobe", {7'd0, dataWrStb}, 8'h01);
    check("R5 data", dataRegOut, 8'h3C);
    check("R5 mode kept", {3'd0, modeOut}, 8'h00);
    @(negedge clk);
    check("R5 strobe single", {7'd0, dataWrStb}, 8'h00);

    // R8 delayed off
    motorReq = 0;
    repeat (DLY) @(negedge clk);
    check("R8 still on", {7'd0, driveEn}, 8'h01);
    @(negedge clk);
    check("R8 off at count", {7'd0, driveEn}, 8'h00);

    // R10 cancel
    motorReq = 1; @(negedge clk);
    motorReq = 0; repeat (5) @(negedge clk);
    motorReq = 1; repeat (DLY + 5) @(negedge clk);
    check("R10 cancelled", {7'd0, driveEn}, 8'h01);
    motorReq = 0; repeat (DLY + 1) @(negedge clk);
    check("R10 later off", {7'd0, driveEn}, 8'h00);

    // R9 immediate off
    hostWrite(1, 1, 8'h04);
    motorReq = 1; @(negedge clk);
    motorReq = 0; @(negedge clk);
    check("R9 immediate", {7'd0, driveEn}, 8'h00);

    // R12 command pass-through
    driveCmdIn = 4'hA; @(negedge clk);
    check("R12 cmd", {4'd0, driveCmdOut}, 8'h0A);
    driveCmdIn = 4'h5; @(negedge clk);
    check("R12 cmd b", {4'd0, driveCmdOut}, 8'h05);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule